// File: doc/BRIEF.md
# Page-Mode DRAM Access Controller

This block sits between an on-chip requester and an asynchronous DRAM whose row and column addresses share one set of address pins and whose data path is eight bits wide. A requester presents a byte address, a direction flag and write data on a valid/ready port. The controller splits the address into a row half and a column half. It strobes the row in with the row strobe and the column with the column strobe. Read data returns as a single-cycle response pulse.

After an access the row stays open. Later requests to the same row cost only a column strobe pulse, with no new row activation. The row is closed for any of three reasons: a request for a different row arrives, the row strobe has been low close to its allowed maximum, or a refresh sequencer asks for the pins. Every analog timing rule is a parameter counted in clock cycles. The controller grants refresh only when both strobes are high and the row has been closed.

Top module: `fpm_dram_ctrl`

## Requirements
- R1: After reset the row strobe, column strobe, write strobe and output-enable strobe are all high (inactive, active-low), the data drive enable is 0, no response is pending, and `req_ready` is 1 when no refresh is requested.
- R2: A request address splits into row = `req_addr[21:11]` and column = `req_addr[10:0]`. The row is on `dram_addr` when the row strobe falls, and the column is on `dram_addr` when the column strobe falls.
- R3: A write is an early write. The write strobe is low and the data is driven (`dq_oe`=1) in the cycle before the column strobe falls. The output-enable strobe stays high for the whole write.
- R4: A read keeps the write strobe high and the output-enable strobe low while the column strobe is low. `dq_i` is sampled on the edge that ends the column pulse. It is returned on `rsp_rdata` with `rsp_valid` high for one cycle, so each read gives exactly one response, in order.
- R5: A request whose row equals the open row is served with a column pulse only. The row strobe does not fall again.
- R6: A request for another row first raises the row strobe, then activates the new row and completes the access with the correct data.
- R7: Each low period of the row strobe lasts at least `T_RAS` cycles.
- R8: Each low period of the row strobe lasts at most `T_RAS_MAX` cycles. Under a long run of same-row requests, the row is closed and reopened.
- R9: The row strobe stays high at least `T_RP` cycles between two low periods.
- R10: Each column pulse is low for exactly `T_CAS` cycles. The column strobe is high for at least `T_CP` cycles between pulses.
- R11: While `ref_req` is high, `req_ready` is 0. An access already under way completes, and then the row is closed. `ref_gnt` is 1 only while both strobes are high, and it is held for as long as `ref_req` is high.
- R12: The column strobe is low only while the row strobe is low. It falls no earlier than `T_RCD` cycles after the row strobe fell.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this cycle when valid |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 22 | Byte address, row in upper half |
| req_wdata | input | 8 | Write data |
| rsp_valid | output | 1 | Read data valid pulse |
| rsp_rdata | output | 8 | Read data |
| ref_req | input | 1 | Refresh sequencer asks for the DRAM |
| ref_gnt | output | 1 | DRAM idle and handed to refresh |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_we_n | output | 1 | Write strobe, active low |
| dram_oe_n | output | 1 | Output enable, active low |
| dram_addr | output | 11 | Multiplexed row/column address |
| dq_o | output | 8 | Data to the pad |
| dq_oe | output | 1 | Pad drive enable |
| dq_i | input | 8 | Data from the pad |

## Verification
The timing properties assume the requester holds a request stable while it waits for `req_ready`. They also assume that `ref_req`, once raised, stays high until the grant has been seen. The stimulus changes inputs only on falling clock edges, keeps `req_valid` high until the handshake completes, and lowers `ref_req` only after observing `ref_gnt`. The bench's DRAM model captures the row and column on strobe edges. It stores and returns data, and it measures every strobe interval independently of the controller.

// File: rtl/fpm_pkg.sv
package fpm_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ACT,
    ST_CSET,
    ST_COL,
    ST_CPRE,
    ST_OPEN,
    ST_PRE
  } fpm_state_e;
endpackage

// File: rtl/fpm_timer.sv
module fpm_timer #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         done
);
  logic [W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load)             cnt_d = load_val;
    else if (cnt_q != '0) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign done = (cnt_q == '0);
endmodule

// File: rtl/fpm_ras_meter.sv
module fpm_ras_meter #(
  parameter int T_RAS     = 5,
  parameter int T_RAS_MAX = 10000,
  parameter int GUARD     = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ras_low,
  output logic min_ok,
  output logic near_max
);
  localparam int RW = $clog2(T_RAS_MAX + 1);
  localparam logic [RW-1:0] CNT_SAT  = RW'(T_RAS_MAX);
  localparam logic [RW-1:0] MIN_THR  = RW'(T_RAS - 1);
  localparam logic [RW-1:0] NEAR_THR = RW'(T_RAS_MAX - GUARD - 1);

  logic [RW-1:0] cnt_q, cnt_d;

  always_comb begin
    if (!ras_low)             cnt_d = '0;
    else if (cnt_q < CNT_SAT) cnt_d = cnt_q + 1'b1;
    else                      cnt_d = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // cnt_q = cycles the strobe has already been low before this cycle
  assign min_ok   = (cnt_q >= MIN_THR);
  assign near_max = (cnt_q >= NEAR_THR);
endmodule

// File: rtl/fpm_row_track.sv
module fpm_row_track #(
  parameter int W = 11
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] row_in,
  input  logic [W-1:0] row_cmp,
  output logic         hit
);
  logic [W-1:0] row_q, row_d;

  always_comb row_d = load ? row_in : row_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) row_q <= '0;
    else        row_q <= row_d;
  end

  assign hit = (row_cmp == row_q);
endmodule

// File: rtl/fpm_dram_ctrl.sv
module fpm_dram_ctrl #(
  parameter int PIN_W     = 11,
  parameter int DW        = 8,
  parameter int TMR_W     = 4,
  parameter int T_RCD     = 2,
  parameter int T_CAS     = 2,
  parameter int T_CP      = 1,
  parameter int T_RAS     = 5,
  parameter int T_RP      = 3,
  parameter int T_RAS_MAX = 10000
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic               req_we,
  input  logic [2*PIN_W-1:0] req_addr,
  input  logic [DW-1:0]      req_wdata,
  output logic               rsp_valid,
  output logic [DW-1:0]      rsp_rdata,
  input  logic               ref_req,
  output logic               ref_gnt,
  output logic               dram_ras_n,
  output logic               dram_cas_n,
  output logic               dram_we_n,
  output logic               dram_oe_n,
  output logic [PIN_W-1:0]   dram_addr,
  output logic [DW-1:0]      dq_o,
  output logic               dq_oe,
  input  logic [DW-1:0]      dq_i
);
  import fpm_pkg::*;

  localparam int GUARD = 1 + T_CAS + T_CP;
  localparam logic [TMR_W-1:0] LD_RCD = TMR_W'(T_RCD - 1);
  localparam logic [TMR_W-1:0] LD_CAS = TMR_W'(T_CAS - 1);
  localparam logic [TMR_W-1:0] LD_CP  = TMR_W'(T_CP - 1);
  localparam logic [TMR_W-1:0] LD_RP  = TMR_W'(T_RP - 1);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_ni;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_ni = rst_sync_q[1];

  fpm_state_e state_q, state_d;
  logic ras_n_q, ras_n_d, cas_n_q, cas_n_d, we_n_q, we_n_d, oe_n_q, oe_n_d;
  logic [PIN_W-1:0] addr_q, addr_d, col_q, col_d;
  logic [DW-1:0]    dq_q, dq_d, rdata_q, rdata_d;
  logic dq_oe_q, dq_oe_d, wr_q, wr_d, rsp_q, rsp_d;
  logic tmr_load, tmr_done, row_load, row_hit, min_ok, near_max;
  logic [TMR_W-1:0] tmr_val;
  logic accept, close_row;

  wire [PIN_W-1:0] req_row = req_addr[2*PIN_W-1:PIN_W];
  wire [PIN_W-1:0] req_col = req_addr[PIN_W-1:0];

  fpm_timer #(.W(TMR_W)) tmr_i (
    .clk(clk), .rst_n(rst_ni), .load(tmr_load), .load_val(tmr_val), .done(tmr_done)
  );

  fpm_ras_meter #(.T_RAS(T_RAS), .T_RAS_MAX(T_RAS_MAX), .GUARD(GUARD)) meter_i (
    .clk(clk), .rst_n(rst_ni), .ras_low(!ras_n_q), .min_ok(min_ok), .near_max(near_max)
  );

  fpm_row_track #(.W(PIN_W)) row_i (
    .clk(clk), .rst_n(rst_ni), .load(row_load), .row_in(req_row),
    .row_cmp(req_row), .hit(row_hit)
  );

  always_comb begin
    unique case (state_q)
      ST_IDLE: req_ready = !ref_req;
      ST_OPEN: req_ready = !ref_req && !near_max && row_hit;
      default: req_ready = 1'b0;
    endcase
  end

  assign accept    = req_valid && req_ready;
  assign close_row = (ref_req || near_max || (req_valid && !row_hit)) && min_ok;
  assign ref_gnt   = (state_q == ST_IDLE) && ref_req;

  always_comb begin
    state_d  = state_q;
    ras_n_d  = ras_n_q;
    cas_n_d  = cas_n_q;
    we_n_d   = we_n_q;
    oe_n_d   = oe_n_q;
    addr_d   = addr_q;
    col_d    = col_q;
    dq_d     = dq_q;
    dq_oe_d  = dq_oe_q;
    wr_d     = wr_q;
    rsp_d    = 1'b0;
    rdata_d  = rdata_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    row_load = 1'b0;
    unique case (state_q)
      ST_IDLE: if (accept) begin
        ras_n_d  = 1'b0;
        addr_d   = req_row;
        row_load = 1'b1;
        col_d    = req_col;
        wr_d     = req_we;
        we_n_d   = !req_we;
        dq_d     = req_wdata;
        dq_oe_d  = req_we;
        tmr_load = 1'b1;
        tmr_val  = LD_RCD;
        state_d  = ST_ACT;
      end
      ST_ACT: if (tmr_done) begin
        cas_n_d  = 1'b0;
        addr_d   = col_q;
        oe_n_d   = wr_q;
        tmr_load = 1'b1;
        tmr_val  = LD_CAS;
        state_d  = ST_COL;
      end
      ST_CSET: begin
        cas_n_d  = 1'b0;
        oe_n_d   = wr_q;
        tmr_load = 1'b1;
        tmr_val  = LD_CAS;
        state_d  = ST_COL;
      end
      ST_COL: if (tmr_done) begin
        cas_n_d  = 1'b1;
        oe_n_d   = 1'b1;
        we_n_d   = 1'b1;
        dq_oe_d  = 1'b0;
        rsp_d    = !wr_q;
        if (!wr_q) rdata_d = dq_i;
        tmr_load = 1'b1;
        tmr_val  = LD_CP;
        state_d  = ST_CPRE;
      end
      ST_CPRE: if (tmr_done) state_d = ST_OPEN;
      ST_OPEN: begin
        if (close_row) begin
          ras_n_d  = 1'b1;
          tmr_load = 1'b1;
          tmr_val  = LD_RP;
          state_d  = ST_PRE;
        end else if (accept) begin
          addr_d  = req_col;
          col_d   = req_col;
          wr_d    = req_we;
          we_n_d  = !req_we;
          dq_d    = req_wdata;
          dq_oe_d = req_we;
          state_d = ST_CSET;
        end
      end
      ST_PRE: if (tmr_done) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      ras_n_q <= 1'b1;
      cas_n_q <= 1'b1;
      we_n_q  <= 1'b1;
      oe_n_q  <= 1'b1;
      addr_q  <= '0;
      col_q   <= '0;
      dq_q    <= '0;
      dq_oe_q <= 1'b0;
      wr_q    <= 1'b0;
      rsp_q   <= 1'b0;
      rdata_q <= '0;
    end else begin
      state_q <= state_d;
      ras_n_q <= ras_n_d;
      cas_n_q <= cas_n_d;
      we_n_q  <= we_n_d;
      oe_n_q  <= oe_n_d;
      addr_q  <= addr_d;
      col_q   <= col_d;
      dq_q    <= dq_d;
      dq_oe_q <= dq_oe_d;
      wr_q    <= wr_d;
      rsp_q   <= rsp_d;
      rdata_q <= rdata_d;
    end
  end

  assign dram_ras_n = ras_n_q;
  assign dram_cas_n = cas_n_q;
  assign dram_we_n  = we_n_q;
  assign dram_oe_n  = oe_n_q;
  assign dram_addr  = addr_q;
  assign dq_o       = dq_q;
  assign dq_oe      = dq_oe_q;
  assign rsp_valid  = rsp_q;
  assign rsp_rdata  = rdata_q;
endmodule

// File: rtl/fpm_dram_ctrl_chk.sv
module fpm_dram_ctrl_chk #(
  parameter int T_RCD     = 2,
  parameter int T_CAS     = 2,
  parameter int T_CP      = 1,
  parameter int T_RAS     = 5,
  parameter int T_RP      = 3,
  parameter int T_RAS_MAX = 10000
) (
  input logic clk,
  input logic rst_n,
  input logic req_ready,
  input logic ref_req,
  input logic ref_gnt,
  input logic rsp_valid,
  input logic dram_ras_n,
  input logic dram_cas_n,
  input logic dram_we_n,
  input logic dram_oe_n,
  input logic dq_oe
);
  localparam logic [15:0] SAT = 16'hFFFF;
  logic [15:0] lo_run, hi_run, cas_lo, cas_hi;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_run <= '0;
      hi_run <= SAT;
      cas_lo <= '0;
      cas_hi <= SAT;
    end else begin
      lo_run <= dram_ras_n ? 16'd0 : ((lo_run == SAT) ? SAT : lo_run + 16'd1);
      hi_run <= !dram_ras_n ? 16'd0 : ((hi_run == SAT) ? SAT : hi_run + 16'd1);
      cas_lo <= dram_cas_n ? 16'd0 : ((cas_lo == SAT) ? SAT : cas_lo + 16'd1);
      cas_hi <= !dram_cas_n ? 16'd0 : ((cas_hi == SAT) ? SAT : cas_hi + 16'd1);
    end
  end

  p_cas_needs_ras_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !dram_cas_n |-> !dram_ras_n);
  p_rcd_r12: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dram_cas_n) |-> lo_run >= 16'(T_RCD));
  p_ras_min_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dram_ras_n) |-> lo_run >= 16'(T_RAS));
  p_ras_max_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !dram_ras_n |-> lo_run < 16'(T_RAS_MAX));
  p_rp_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dram_ras_n) |-> hi_run >= 16'(T_RP));
  p_cas_width_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dram_cas_n) |-> cas_lo == 16'(T_CAS));
  p_cp_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dram_cas_n) |-> cas_hi >= 16'(T_CP));
  p_early_we_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(dram_cas_n) && !dram_we_n) |-> ($past(!dram_we_n) && $past(dq_oe)));
  p_no_oe_on_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
    dq_oe |-> dram_oe_n);
  p_rsp_at_cas_end_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> ($rose(dram_cas_n) && $past(!dram_oe_n)));
  p_rsp_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);
  p_gnt_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ref_gnt |-> (dram_ras_n && dram_cas_n));
  p_no_accept_ref_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ref_req |-> !req_ready);
endmodule

bind fpm_dram_ctrl fpm_dram_ctrl_chk #(
  .T_RCD(T_RCD), .T_CAS(T_CAS), .T_CP(T_CP), .T_RAS(T_RAS), .T_RP(T_RP),
  .T_RAS_MAX(T_RAS_MAX)
) chk_i (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .ref_req(ref_req),
  .ref_gnt(ref_gnt), .rsp_valid(rsp_valid), .dram_ras_n(dram_ras_n),
  .dram_cas_n(dram_cas_n), .dram_we_n(dram_we_n), .dram_oe_n(dram_oe_n),
  .dq_oe(dq_oe)
);

// File: tb/fpm_dram_ctrl_tb_top.sv
module fpm_dram_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int T_RCD = 2, T_CAS = 2, T_CP = 1, T_RAS = 5, T_RP = 3, T_RAS_MAX = 40;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_we = 1'b0, ref_req = 1'b0;
  logic [21:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic req_ready, rsp_valid, ref_gnt;
  logic [7:0] rsp_rdata, dq_o, dq_i;
  logic dram_ras_n, dram_cas_n, dram_we_n, dram_oe_n, dq_oe;
  logic [10:0] dram_addr;

  always #(CLK_PERIOD/2) clk = ~clk;

  fpm_dram_ctrl #(.T_RCD(T_RCD), .T_CAS(T_CAS), .T_CP(T_CP), .T_RAS(T_RAS),
                  .T_RP(T_RP), .T_RAS_MAX(T_RAS_MAX)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_we(req_we), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .ref_req(ref_req), .ref_gnt(ref_gnt),
    .dram_ras_n(dram_ras_n), .dram_cas_n(dram_cas_n), .dram_we_n(dram_we_n),
    .dram_oe_n(dram_oe_n), .dram_addr(dram_addr), .dq_o(dq_o), .dq_oe(dq_oe), .dq_i(dq_i)
  );

  function automatic int idx_of(logic [10:0] row, logic [10:0] col);
    return int'({row[1:0], col[3:0]});
  endfunction
  function automatic logic [7:0] init_val(int i);
    return 8'(i * 37 + 5);
  endfunction

  // ---------------- DRAM model, sampled at each rising edge ----------------
  logic [7:0]  mem [64];
  logic [10:0] row_l, col_l;
  logic m_ras, m_cas, m_we;
  int m_lo, m_hi, m_clo, m_chi, act_cnt;
  int v_rcd, v_rmin, v_rmax, v_rp, v_cas, v_cp, v_ew, v_oe, v_rdwe;

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 64; i++) mem[i] <= init_val(i);
      m_ras <= 1'b1; m_cas <= 1'b1; m_we <= 1'b1;
      m_lo <= 0; m_hi <= 100; m_clo <= 0; m_chi <= 100;
      row_l <= '0; col_l <= '0; act_cnt <= 0;
      v_rcd <= 0; v_rmin <= 0; v_rmax <= 0; v_rp <= 0; v_cas <= 0;
      v_cp <= 0; v_ew <= 0; v_oe <= 0; v_rdwe <= 0;
    end else begin
      m_ras <= dram_ras_n; m_cas <= dram_cas_n; m_we <= dram_we_n;
      if (!dram_ras_n) begin m_lo <= m_lo + 1; m_hi <= 0; end
      else             begin m_hi <= m_hi + 1; m_lo <= 0; end
      if (!dram_cas_n) begin m_clo <= m_clo + 1; m_chi <= 0; end
      else             begin m_chi <= m_chi + 1; m_clo <= 0; end
      if (!dram_ras_n && m_ras) begin
        act_cnt <= act_cnt + 1;
        row_l <= dram_addr;
        if (m_hi < T_RP) v_rp <= v_rp + 1;
      end
      if (dram_ras_n && !m_ras && m_lo < T_RAS) v_rmin <= v_rmin + 1;
      if (!dram_ras_n && m_lo + 1 > T_RAS_MAX) v_rmax <= v_rmax + 1;
      if (!dram_cas_n && m_cas) begin
        col_l <= dram_addr;
        if (dram_ras_n || m_lo < T_RCD) v_rcd <= v_rcd + 1;
        if (m_chi < T_CP) v_cp <= v_cp + 1;
        if (!dram_we_n) begin
          if (m_we || !dq_oe) v_ew <= v_ew + 1;
          mem[idx_of(row_l, dram_addr)] <= dq_o;
        end else if (dram_oe_n) v_rdwe <= v_rdwe + 1;
      end
      if (!dram_we_n && !dram_oe_n) v_oe <= v_oe + 1;
      if (dram_cas_n && !m_cas && m_clo != T_CAS) v_cas <= v_cas + 1;
    end
  end

  assign dq_i = (!dram_oe_n && !dram_cas_n) ? mem[idx_of(row_l, col_l)] : 8'h00;

  // ---------------- scoreboard ----------------
  int checks = 0, errors = 0, mon_checks = 0, mon_errors = 0;
  int n_rd_req = 0, n_rsp = 0;
  logic [7:0] exp_mem [64];
  logic [7:0] exp_rd [$];

  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      mon_checks++;
      if (n_rsp >= exp_rd.size()) begin
        mon_errors++;
        $display("FAIL R4: unexpected response actual %0h expected none", rsp_rdata);
      end else if (rsp_rdata !== exp_rd[n_rsp]) begin
        mon_errors++;
        $display("FAIL R4: read data actual %0h expected %0h", rsp_rdata, exp_rd[n_rsp]);
      end
      n_rsp++;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_req(input bit we, input logic [10:0] row, input logic [10:0] col,
                        input logic [7:0] d);
    int i;
    @(negedge clk);
    req_valid = 1'b1; req_we = we; req_addr = {row, col}; req_wdata = d;
    forever begin
      #1;
      if (req_ready) break;
      @(negedge clk);
    end
    i = idx_of(row, col);
    if (we) exp_mem[i] = d;
    else begin exp_rd.push_back(exp_mem[i]); n_rd_req++; end
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic drain();
    for (int k = 0; k < 60 && n_rsp != n_rd_req; k++) @(negedge clk);
    @(negedge clk);
  endtask

  bit done = 1'b0;
  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors",
               checks + mon_checks + 1, errors + mon_errors + 1);
      $finish;
    end
  end

  initial begin
    int a0, seen, bad, rsp0;
    logic [10:0] rows [4];
    rows[0] = 11'h000; rows[1] = 11'h001; rows[2] = 11'h002; rows[3] = 11'h7FF;
    for (int i = 0; i < 64; i++) exp_mem[i] = init_val(i);
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk(dram_ras_n && dram_cas_n && dram_we_n && dram_oe_n, "R1 strobes high",
        {dram_ras_n, dram_cas_n, dram_we_n, dram_oe_n}, 15);
    chk(!dq_oe && !rsp_valid, "R1 no drive/response", {dq_oe, rsp_valid}, 0);
    chk(req_ready, "R1 ready", req_ready, 1);

    // R5 / R2 / R3: write then two reads in one row
    a0 = act_cnt;
    do_req(1'b1, 11'h7FF, 11'h40F, 8'hA5);
    do_req(1'b0, 11'h7FF, 11'h40F, 8'h00);
    do_req(1'b0, 11'h7FF, 11'h403, 8'h00);
    drain();
    chk(act_cnt - a0 == 1, "R5 single activation for page hits", act_cnt - a0, 1);
    chk(row_l == 11'h7FF, "R2 row on address pins", row_l, 11'h7FF);
    chk(col_l == 11'h403, "R2 column on address pins", col_l, 11'h403);
    chk(mem[idx_of(11'h7FF, 11'h40F)] == 8'hA5, "R3 early write stored",
        mem[idx_of(11'h7FF, 11'h40F)], 8'hA5);

    // R6 miss
    a0 = act_cnt;
    do_req(1'b0, 11'h001, 11'h007, 8'h00);
    drain();
    chk(act_cnt - a0 == 1, "R6 miss reactivates", act_cnt - a0, 1);
    chk(row_l == 11'h001, "R6 new row captured", row_l, 1);

    // R8 long hit run forces close/reopen
    a0 = act_cnt;
    for (int k = 0; k < 12; k++) do_req(k[0], 11'h002, 11'(k), 8'(8'h30 + k));
    drain();
    chk(act_cnt - a0 >= 2, "R8 row reopened under long run", act_cnt - a0, 2);

    // R11 refresh with row open and idle
    @(negedge clk); ref_req = 1'b1;
    seen = 0;
    for (int k = 0; k < 40 && !seen; k++) begin @(negedge clk); if (ref_gnt) seen = 1; end
    chk(seen == 1, "R11 grant given", seen, 1);
    chk(dram_ras_n && dram_cas_n, "R11 strobes high at grant", {dram_ras_n, dram_cas_n}, 3);
    a0 = act_cnt; bad = 0;
    req_valid = 1'b1; req_we = 1'b0; req_addr = {11'h002, 11'h001};
    for (int k = 0; k < 8; k++) begin
      #1; if (req_ready || !ref_gnt) bad++;
      @(negedge clk);
    end
    chk(bad == 0, "R11 no accept while refresh held", bad, 0);
    chk(act_cnt == a0, "R11 no activation during refresh", act_cnt - a0, 0);
    req_valid = 1'b0; ref_req = 1'b0;

    // R11 refresh raised during an access
    rsp0 = n_rsp;
    do_req(1'b0, 11'h000, 11'h00C, 8'h00);
    ref_req = 1'b1;
    seen = 0;
    for (int k = 0; k < 40 && !seen; k++) begin @(negedge clk); if (ref_gnt) seen = 1; end
    chk(seen == 1 && n_rsp == rsp0 + 1, "R11 access finished before grant", n_rsp - rsp0, 1);
    @(negedge clk); ref_req = 1'b0;

    // random mix
    for (int n = 0; n < 300; n++) begin
      int r, g;
      r = int'($urandom_range(3, 0));
      g = int'($urandom_range(3, 0));
      do_req(1'($urandom), rows[r], 11'($urandom), 8'($urandom));
      repeat (g) @(negedge clk);
    end
    drain();

    chk(n_rsp == n_rd_req, "R4 one response per read", n_rsp, n_rd_req);
    chk(v_rdwe == 0, "R4 read strobes (WE high, OE low)", v_rdwe, 0);
    chk(v_ew == 0, "R3 write strobe/data before column strobe", v_ew, 0);
    chk(v_oe == 0, "R3 output enable off during write", v_oe, 0);
    chk(v_rmin == 0, "R7 row strobe minimum low", v_rmin, 0);
    chk(v_rmax == 0, "R8 row strobe maximum low", v_rmax, 0);
    chk(v_rp == 0, "R9 row precharge", v_rp, 0);
    chk(v_cas == 0 && v_cp == 0, "R10 column pulse and precharge", v_cas + v_cp, 0);
    chk(v_rcd == 0, "R12 row-to-column delay", v_rcd, 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors",
             checks + mon_checks, errors + mon_errors);
    $finish;
  end
endmodule